// File: doc/BRIEF.md
# Nonvolatile Store Program Sequencer

This block decides whether the value held in a DAC's volatile control register is committed into its nonvolatile shadow, and it paces that commit. A serial slave beside it reports how many bits of the current frame it has taken in (`frame_bits`) and pulses `ser_edge` once for each rising edge of the serial clock. When the frame has delivered its last data bit, the sequencer samples the program request on the next serial edge. If the request is absent there, it samples once more on the edge after that.

An accepted request is gated by a single supply-OK bit. If the supply is good, the sequencer snapshots the volatile code and holds the ready/busy output low for a fixed number of serial clock edges. While it is busy it tells the serial slave to ignore its data input and to keep its data output silent. At the end it writes the snapshot into the shadow register and then releases ready/busy.

The state machine has five states. `ST_IDLE` waits for a completed frame. `ST_GRACE` is the one extra edge allowed for a late request. `ST_BUSY` counts the write interval. `ST_COMMIT` is the single cycle in which the new shadow value is visible while busy is still shown. `ST_HOLD` waits for the frame counter to leave its end value, so that one completed frame never yields two stores.

The transitions are as follows:
- `ST_IDLE` goes to `ST_BUSY` on an accepted request, to `ST_HOLD` on a request made with a low supply, and to `ST_GRACE` when the request is absent.
- `ST_GRACE` goes to `ST_BUSY`, to `ST_HOLD` (a late or failed request), or back to `ST_IDLE` when select drops.
- `ST_BUSY` goes to `ST_COMMIT` on the last counted edge.
- `ST_COMMIT` goes to `ST_HOLD`.
- `ST_HOLD` goes to `ST_IDLE` once `frame_bits` changes.

Top module: `nvs_prog_seq`

## Requirements
- R1: After reset `rdy_bsy` is 1, `serial_mute` is 0 and `nv_code` equals the parameter `NV_INIT`.
- R2: Suppose `cs_act` is 1, `frame_bits` equals `FRAME_BITS` (11: start bit, two address bits, eight data bits) and `prog_req` and `supply_ok` are both 1 on a `ser_edge` cycle. Then `rdy_bsy` reads 0 in the next clock cycle.
- R3: If `prog_req` is 0 on that first edge after the last data bit but 1 on the following `ser_edge`, the store is still accepted and `rdy_bsy` reads 0 in the next cycle.
- R4: If `prog_req` is 0 on both of those edges, or if `cs_act` falls between them, no store occurs: `rdy_bsy` stays 1 and `nv_code` is unchanged.
- R5: If `supply_ok` is 0 on the accepting edge, `rdy_bsy` stays 1 and `nv_code` is unchanged.
- R6: Busy lasts exactly `WR_TICKS` `ser_edge` pulses counted after acceptance. With no pulses, `rdy_bsy` stays 0 for any number of cycles.
- R7: `serial_mute` is 1 exactly while `rdy_bsy` is 0.
- R8: The stored value is the `vol_code` present on the accepting edge. Later changes of `vol_code` do not affect it.
- R9: On the cycle after the last counted pulse, `nv_code` shows the new value while `rdy_bsy` is still 0. One cycle later `rdy_bsy` is 1. `nv_code` never changes while `rdy_bsy` is 1.
- R10: `prog_req` held high during busy, and after it while `frame_bits` still equals `FRAME_BITS`, starts no further store.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_act | input | 1 | Chip select, high while a frame is in progress |
| ser_edge | input | 1 | One-cycle pulse per serial clock rising edge |
| frame_bits | input | POS_W | Bits received in the current frame, from the serial slave |
| prog_req | input | 1 | Program request level |
| supply_ok | input | 1 | Supply detector, 1 when programming is possible |
| vol_code | input | DATA_W | Current volatile control register value |
| rdy_bsy | output | 1 | 1 = ready, 0 = store in progress |
| serial_mute | output | 1 | Tells the serial slave to ignore data in and silence data out |
| nv_code | output | DATA_W | Nonvolatile shadow value |

## Verification
Each decision falls on a clock edge where `ser_edge` is high, and its effect on `rdy_bsy` and `serial_mute` appears one cycle later. The bench therefore drives `ser_edge` for one cycle between falling edges and samples on the next falling edge. The new `nv_code` appears on the cycle after the `WR_TICKS`-th counted pulse, and ready returns one cycle after that. The bench counts its own pulses and samples at exactly those two points. Random gaps between pulses are checked to leave busy held. Expected codes come from a bench-side model of the shadow that is updated only when the bench's own rules say a store is accepted.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_GRACE  = 3'd1,
        ST_BUSY   = 3'd2,
        ST_COMMIT = 3'd3,
        ST_HOLD   = 3'd4
    } nvs_state_e;
endpackage

// File: rtl/nvs_tick_timer.sv
module nvs_tick_timer #(
    parameter int TICKS = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic last
);
    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST_V = CW'(TICKS - 1);

    logic [CW-1:0] cnt_q;

    assign last = run && (cnt_q == LAST_V);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear || last)
            cnt_q <= '0;
        else if (run)
            cnt_q <= cnt_q + 1'b1;
    end

    // R6: without a serial edge the interval count pauses
    p_count_pause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clear) |=> $stable(cnt_q));
endmodule

// File: rtl/nvs_shadow_reg.sv
module nvs_shadow_reg #(
    parameter int                 DATA_W = 8,
    parameter logic [DATA_W-1:0]  INIT   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= INIT;
        else if (wr)
            q <= din;
    end
endmodule

// File: rtl/nvs_prog_seq.sv
module nvs_prog_seq
    import nvs_pkg::*;
#(
    parameter int                DATA_W     = 8,
    parameter int                POS_W      = 4,
    parameter int                FRAME_BITS = 11,
    parameter int                WR_TICKS   = 4000,
    parameter logic [DATA_W-1:0] NV_INIT    = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              ser_edge,
    input  logic [POS_W-1:0]  frame_bits,
    input  logic              prog_req,
    input  logic              supply_ok,
    input  logic [DATA_W-1:0] vol_code,
    output logic              rdy_bsy,
    output logic              serial_mute,
    output logic [DATA_W-1:0] nv_code
);
    localparam logic [POS_W-1:0] END_POS = POS_W'(FRAME_BITS);

    nvs_state_e        state_q, state_d;
    logic [DATA_W-1:0] snap_q;
    logic              frame_end, accept, timer_run, timer_last, nv_wr;

    assign frame_end = (frame_bits == END_POS);
    assign accept    = ser_edge && prog_req && supply_ok &&
                       ((state_q == ST_IDLE && cs_act && frame_end) ||
                        (state_q == ST_GRACE && cs_act));
    assign timer_run = (state_q == ST_BUSY) && ser_edge;
    assign nv_wr     = (state_q == ST_BUSY) && timer_last;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ser_edge && cs_act && frame_end) begin
                    if (prog_req) state_d = supply_ok ? ST_BUSY : ST_HOLD;
                    else          state_d = ST_GRACE;
                end
            end
            ST_GRACE: begin
                if (!cs_act)
                    state_d = ST_IDLE;
                else if (ser_edge)
                    state_d = (prog_req && supply_ok) ? ST_BUSY : ST_HOLD;
            end
            ST_BUSY:   if (timer_last) state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_HOLD;
            ST_HOLD:   if (!frame_end) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      snap_q <= NV_INIT;
        else if (accept) snap_q <= vol_code;
    end

    always_comb begin
        rdy_bsy     = 1'b1;
        serial_mute = 1'b0;
        unique case (state_q)
            ST_BUSY, ST_COMMIT: begin
                rdy_bsy     = 1'b0;
                serial_mute = 1'b1;
            end
            default: ;
        endcase
    end

    nvs_tick_timer #(.TICKS(WR_TICKS)) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .run   (timer_run),
        .last  (timer_last)
    );

    nvs_shadow_reg #(.DATA_W(DATA_W), .INIT(NV_INIT)) shadow_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (nv_wr),
        .din   (snap_q),
        .q     (nv_code)
    );

    // R2, R3: an accepted request shows busy on the next cycle
    p_busy_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_edge && cs_act && prog_req && supply_ok &&
         ((state_q == ST_IDLE && frame_end) || state_q == ST_GRACE)) |=> !rdy_bsy);

    // R4: a request missing on the grace edge never starts busy
    p_late_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GRACE && ser_edge && !prog_req) |=> rdy_bsy);

    // R5: a low supply keeps ready high
    p_supply_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_edge && !supply_ok && (state_q == ST_IDLE || state_q == ST_GRACE)) |=> rdy_bsy);

    // R9: the commit cycle is followed by ready
    p_commit_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMMIT) |=> rdy_bsy);

    // R9: the shadow never moves while ready is shown
    p_nv_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_bsy && $past(rdy_bsy)) |-> $stable(nv_code));

    // R10: a store cannot begin again straight out of commit
    p_no_rearm_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMMIT) |=> (state_q == ST_HOLD));
endmodule

// File: tb/nvs_prog_seq_tb.sv
module nvs_prog_seq_tb_top;
    localparam int DW = 8;
    localparam int PW = 4;
    localparam int FB = 11;
    localparam int WT = 6;
    localparam logic [DW-1:0] INIT = 8'h5A;

    logic clk = 0, rst_n = 0;
    logic cs_act = 0, ser_edge = 0, prog_req = 0, supply_ok = 1;
    logic [PW-1:0] frame_bits = '0;
    logic [DW-1:0] vol_code = '0;
    logic rdy_bsy, serial_mute;
    logic [DW-1:0] nv_code;

    int checks = 0, errors = 0;
    logic [DW-1:0] exp_nv;
    bit finished = 0;

    always #2 clk = ~clk;

    nvs_prog_seq #(.DATA_W(DW), .POS_W(PW), .FRAME_BITS(FB),
                   .WR_TICKS(WT), .NV_INIT(INIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .ser_edge(ser_edge),
        .frame_bits(frame_bits), .prog_req(prog_req), .supply_ok(supply_ok),
        .vol_code(vol_code), .rdy_bsy(rdy_bsy), .serial_mute(serial_mute),
        .nv_code(nv_code));

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit store_expected(input int kind, input bit sup);
        return (kind == 0 || kind == 1) && sup;
    endfunction

    task automatic pulse();
        ser_edge = 1;
        @(negedge clk);
        ser_edge = 0;
    endtask

    task automatic run_frame(input int kind, input logic [DW-1:0] data, input bit sup);
        bit st;
        st = store_expected(kind, sup);
        @(negedge clk);
        cs_act = 1; frame_bits = PW'(FB); vol_code = data; supply_ok = sup;
        prog_req = (kind == 0);
        pulse();
        if (kind != 0) begin
            chk(rdy_bsy, 1, "R3 no busy before grace edge");
            prog_req = (kind == 1);
            if (kind == 3) cs_act = 0;
            @(negedge clk);
            if (kind != 3) pulse();
        end
        if (!st) begin
            chk(rdy_bsy, 1, sup ? "R4 dropped store" : "R5 low supply");
            chk(nv_code, exp_nv, "R4/R5 shadow unchanged");
        end else begin
            chk(rdy_bsy, 0, kind == 0 ? "R2 busy start" : "R3 grace accept");
            chk(serial_mute, 1, "R7 mute during busy");
            vol_code = ~data;
            prog_req = 1;
            for (int k = 1; k <= WT; k++) begin
                pulse();
                if (k < WT) begin
                    chk(rdy_bsy, 0, "R6 busy before last tick");
                    for (int g = 0; g < int'($urandom_range(0, 3)); g++) @(negedge clk);
                    chk(rdy_bsy, 0, "R6 busy holds without edges");
                end
            end
            chk(rdy_bsy, 0, "R9 commit cycle still busy");
            chk(nv_code, data, "R8 R9 stored snapshot");
            exp_nv = data;
            @(negedge clk);
            chk(rdy_bsy, 1, "R9 ready after commit");
            chk(serial_mute, 0, "R7 mute released");
            pulse(); pulse();
            chk(rdy_bsy, 1, "R10 no second store");
            chk(nv_code, exp_nv, "R10 shadow kept");
        end
        prog_req = 0; frame_bits = '0; cs_act = 0;
        @(negedge clk); @(negedge clk);
        chk(rdy_bsy, 1, "R1 idle ready");
    endtask

    initial begin
        void'($urandom(32'h1234_abcd));
        exp_nv = INIT;
        repeat (3) @(negedge clk);
        chk(rdy_bsy, 1, "R1 reset ready");
        chk(serial_mute, 0, "R1 reset mute");
        chk(nv_code, INIT, "R1 reset shadow");
        rst_n = 1;
        @(negedge clk);
        run_frame(0, 8'hFF, 1);
        run_frame(1, 8'h00, 1);
        run_frame(2, 8'h3C, 1);
        run_frame(3, 8'hC3, 1);
        run_frame(0, 8'h81, 0);
        run_frame(1, 8'h7E, 0);
        for (int i = 0; i < 40; i++)
            run_frame(int'($urandom_range(0, 3)), DW'($urandom), bit'($urandom_range(0, 3) != 0));
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule